// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A free-running frame counter divides time into fixed frames of `W + 3` clock cycles; with the default 8-bit width that is an 11-cycle frame. A decoder turns the count into four mutually exclusive strobes: a track/hold enable for the external sample-and-hold, a bit-resolve step, a result-capture strobe and a clear strobe. While the steps run, the block drives a trial code to an external DAC and reads a single comparator bit back. It resolves one bit per step, most significant first.

The finished code is copied into a separate result register. That register drives the converter's output DAC, so the published value does not change while the next frame is being resolved. A one-cycle `done` pulse marks every capture. The analog comparator, both DACs and the sample-and-hold circuit are external to the block.

Top module: `sar_conv_seq`

## Requirements
- R1: While running, the frame repeats every W+3 cycles. Frame position 0 raises `sh_en`, positions 1..W raise `step_en`, position W+1 raises `load_en` and position W+2 raises `clr_en`. Exactly one of these strobes is high in every running cycle, and a `clr_en` cycle is always followed by an `sh_en` cycle.
- R2: In step position k (1..W), `dac_code` carries trial bit W-k set to 1 and all lower bits at 0. Higher bits hold the values already resolved in this frame.
- R3: At the end of a step cycle, the trial bit keeps the value 1 if `cmp_in` is 1 (input at or above the DAC level) and becomes 0 otherwise.
- R4: With an ideal comparator (5 V reference, one step = 5/256 V), each captured code equals floor(Vin/step), limited to 255 for inputs at or above full scale.
- R5: `out_code` changes only in the cycle after `load_en`. It keeps its value through every other cycle, including the clear cycle and the next frame's steps.
- R6: `done` is high for exactly the one cycle after each `load_en`, and in that cycle `out_code` already shows the new result.
- R7: The clear cycle empties the trial register, so `dac_code` is 0 throughout every `sh_en` cycle.
- R8: `rst_n` low acts at once, without waiting for a clock edge. It forces all strobes, `done`, `dac_code` and `out_code` to 0, and the strobes stay low until the synchronised release takes effect.
- R9: After reset is released, the first strobe raised is `sh_en`, which starts a full frame. `out_code` stays 0 until the first `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmp_in | input | 1 | Comparator result: 1 when held input is at or above the DAC level |
| sh_en | output | 1 | Track/hold enable for the external sample-and-hold |
| step_en | output | 1 | One bit is being resolved this cycle |
| load_en | output | 1 | Result register captures the trial register at the end of this cycle |
| clr_en | output | 1 | Trial register is cleared at the end of this cycle |
| dac_code | output | W | Trial code driven to the feedback DAC |
| out_code | output | W | Held conversion result for the output DAC |
| done | output | 1 | One-cycle pulse marking a fresh `out_code` |

## Verification
The bench builds the block with W = 8 and a 5-bit frame counter, which gives the 11-cycle frame. At this size every one of the 256 output codes can be driven in turn. Each code is applied once at the middle of its step and once exactly on its lower threshold, and inputs above full scale and at zero are added as well, so that every decision path of every bit is taken. A cycle-accurate model of the frame in the bench compares the strobes, the trial code of each step and the held result in every cycle. The bench also pulls reset in the middle of a frame to check the asynchronous clear and the clean restart that follows.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobe bundle produced by the frame decoder
  typedef struct packed {
    logic track;   // sample/hold enable
    logic step;    // resolve one bit
    logic load;    // capture into result register
    logic clear;   // empty the trial register
  } sar_strobe_t;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run = sync_q[STAGES-1];

endmodule

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr #(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] pos
);

  localparam int FRAME = W + 3;
  localparam int LAST  = FRAME - 1;

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;
  logic             pos_en;

  assign pos_en = run;

  always_comb begin
    if (pos_q == CNT_W'(LAST)) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/sar_strobe_dec.sv
module sar_strobe_dec
  import sar_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic             run,
  input  logic [CNT_W-1:0] pos,
  output sar_strobe_t      stb,
  output logic [W-1:0]     trial_mask
);

  localparam int LOAD_POS  = W + 1;
  localparam int CLEAR_POS = W + 2;

  always_comb begin
    stb.track = run && (pos == '0);
    stb.step  = run && (pos != '0) && (pos <= CNT_W'(W));
    stb.load  = run && (pos == CNT_W'(LOAD_POS));
    stb.clear = run && (pos == CNT_W'(CLEAR_POS));
  end

  // Bit i is under trial in frame position W-i
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign trial_mask[i] = run && (pos == CNT_W'(W - i));
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] trial_mask,
  input  logic         cmp_in,
  output logic [W-1:0] resolved,
  output logic [W-1:0] dac_code
);

  logic [W-1:0] bits_q;
  logic [W-1:0] bits_d;
  logic         bits_en;

  assign bits_en = clear || (trial_mask != '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (clear) begin
        bits_d[i] = 1'b0;
      end else if (trial_mask[i]) begin
        bits_d[i] = cmp_in;
      end else begin
        bits_d[i] = bits_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (bits_en) begin
      bits_q <= bits_d;
    end
  end

  assign resolved = bits_q;
  assign dac_code = bits_q | trial_mask;

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] resolved,
  output logic [W-1:0] out_code,
  output logic         done
);

  logic [W-1:0] res_q;
  logic [W-1:0] res_d;
  logic         done_q;
  logic         done_d;

  always_comb begin
    res_d  = resolved;
    done_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (load) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign out_code = res_q;
  assign done     = done_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_in,
  output logic         sh_en,
  output logic         step_en,
  output logic         load_en,
  output logic         clr_en,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] out_code,
  output logic         done
);

  logic             run;
  logic [CNT_W-1:0] pos;
  sar_strobe_t      stb;
  logic [W-1:0]     trial_mask;
  logic [W-1:0]     resolved;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  sar_frame_ctr #(.W(W), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .pos   (pos)
  );

  sar_strobe_dec #(.W(W), .CNT_W(CNT_W)) u_dec (
    .run        (run),
    .pos        (pos),
    .stb        (stb),
    .trial_mask (trial_mask)
  );

  sar_trial_reg #(.W(W)) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (stb.clear),
    .trial_mask (trial_mask),
    .cmp_in     (cmp_in),
    .resolved   (resolved),
    .dac_code   (dac_code)
  );

  sar_result_reg #(.W(W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stb.load),
    .resolved (resolved),
    .out_code (out_code),
    .done     (done)
  );

  assign sh_en   = stb.track;
  assign step_en = stb.step;
  assign load_en = stb.load;
  assign clr_en  = stb.clear;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmp_in,
  input logic         sh_en,
  input logic         step_en,
  input logic         load_en,
  input logic         clr_en,
  input logic [W-1:0] trial_mask,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] out_code,
  input logic         done
);

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_en, step_en, load_en, clr_en}));

  p_clr_to_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> sh_en);

  p_load_after_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> $past(step_en));

  p_trial_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> ($onehot(trial_mask) && ((dac_code & trial_mask) == trial_mask)));

  p_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_en) |->
      ((dac_code & $past(trial_mask)) == ($past(cmp_in) ? $past(trial_mask) : '0)));

  p_hold_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_en) |-> $stable(out_code));

  p_done_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> done);

  p_done_only_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(load_en));

  p_sample_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |-> (dac_code == '0));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_in     (cmp_in),
  .sh_en      (sh_en),
  .step_en    (step_en),
  .load_en    (load_en),
  .clr_en     (clr_en),
  .trial_mask (trial_mask),
  .dac_code   (dac_code),
  .out_code   (out_code),
  .done       (done)
);

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;

  localparam int  W        = 8;
  localparam int  CNT_W    = 5;
  localparam int  CLK_T    = 10;
  localparam int  FRAME    = W + 3;
  localparam int  N_MAIN   = 2 * 256 + 3;
  localparam int  N_TAIL   = 3;
  localparam real VREF     = 5.0;
  localparam real LSB_V    = VREF / 256.0;

  logic         clk;
  logic         rst_n;
  logic         cmp_in;
  logic         sh_en, step_en, load_en, clr_en, done;
  logic [W-1:0] dac_code, out_code;

  int  n_checks;
  int  n_errs;
  int  frames_done;
  bit  finished;

  real vin_in;
  real vin_held;

  sar_conv_seq #(.W(W), .CNT_W(CNT_W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_in   (cmp_in),
    .sh_en    (sh_en),
    .step_en  (step_en),
    .load_en  (load_en),
    .clr_en   (clr_en),
    .dac_code (dac_code),
    .out_code (out_code),
    .done     (done)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  // Analog models: sample-and-hold and ideal comparator
  always @(posedge clk) begin
    if (sh_en) vin_held <= vin_in;
  end
  assign cmp_in = (vin_held >= (real'(dac_code) * LSB_V));

  function automatic real vin_of(int idx);
    if (idx < 256) return (real'(idx) + 0.5) * LSB_V;
    if (idx < 512) return real'(idx - 256) * LSB_V;
    if (idx == 512) return 5.3;
    if (idx == 513) return 0.0;
    return 4.999;
  endfunction

  function automatic int exp_code(real v);
    real q;
    q = $floor(v / LSB_V);
    if (q > 255.0) return 255;
    if (q < 0.0) return 0;
    return int'(q);
  endfunction

  function automatic logic [3:0] exp_stb(int fc);
    if (fc == 0) return 4'b1000;
    if (fc <= W) return 4'b0100;
    if (fc == W + 1) return 4'b0010;
    return 4'b0001;
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  // Cycle monitor: frame model, trial codes, held result
  bit           started;
  bit           first_after_rst;
  int           fc;
  int           exp_cur;
  logic [W-1:0] prev_out;

  always @(negedge clk) begin
    if (!rst_n) begin
      started         <= 1'b0;
      first_after_rst <= 1'b1;
      fc              <= 0;
      prev_out        <= '0;
    end else begin
      logic [3:0] act_stb;
      int         exp_d;
      int         b;
      act_stb = {sh_en, step_en, load_en, clr_en};
      if (!started && act_stb != 4'b0000) begin
        // R9: the first strobe after release is the track strobe
        check("R9", act_stb == 4'b1000, act_stb, 4'b1000);
        started = 1'b1;
        fc = 0;
      end
      if (started) begin
        check("R1", act_stb == exp_stb(fc), act_stb, exp_stb(fc));
        if (fc == 0) begin
          check("R7", dac_code == '0, dac_code, 0);
        end
        if (fc == 1) exp_cur = exp_code(vin_held);
        if (fc >= 1 && fc <= W) begin
          b = W - fc;
          exp_d = ((exp_cur >> (b + 1)) << (b + 1)) | (1 << b);
          check("R2/R3", dac_code == W'(exp_d), dac_code, exp_d);
        end
        if (done) begin
          check("R6", fc == W + 2, fc, W + 2);
          check("R4", out_code == W'(exp_cur), out_code, exp_cur);
          frames_done = frames_done + 1;
          vin_in = vin_of(frames_done);
        end else begin
          check("R5", out_code == prev_out, out_code, prev_out);
        end
        if (first_after_rst && !done) begin
          check("R9", out_code == '0, out_code, 0);
        end
        if (done) first_after_rst = 1'b0;
        fc = (fc == FRAME - 1) ? 0 : fc + 1;
      end else begin
        check("R8", {act_stb, done} == 5'b0, {act_stb, done}, 0);
      end
      prev_out = out_code;
    end
  end

  task automatic check_reset_state();
    check("R8", {sh_en, step_en, load_en, clr_en, done} == 5'b0,
          {sh_en, step_en, load_en, clr_en, done}, 0);
    check("R8", dac_code == '0, dac_code, 0);
    check("R8", out_code == '0, out_code, 0);
  endtask

  initial begin
    n_checks    = 0;
    n_errs      = 0;
    frames_done = 0;
    finished    = 1'b0;
    vin_in      = vin_of(0);
    vin_held    = 0.0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    wait (frames_done == N_MAIN);
    // Mid-frame asynchronous reset
    repeat (4) @(negedge clk);
    #(CLK_T / 4);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    repeat (3) @(negedge clk);
    check_reset_state();
    vin_in = vin_of(100);
    rst_n  = 1'b1;
    wait (frames_done == N_MAIN + N_TAIL);
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames_done, N_MAIN + N_TAIL);
    report();
  end

endmodule